// File: doc/BRIEF.md
# Serial Channel DMA Ready-Request Logic

This block drives the active-low ready-request line that one serial controller channel uses to pace a DMA engine. It holds a small control byte written by the host, a one-byte transmit holding register with a buffer-empty flag, and a three-entry receive character queue with a character-available flag and a sticky overrun flag. Depending on the control byte, the ready line follows either the transmit buffer-empty status or the receive character-available status. It can also be forced to not-ready, or it can be left untouched when the alternative wait behaviour is chosen.

The host writes the control byte with `ctl_wr`, writes transmit bytes with `data_wr` and reads received bytes with `data_rd`. A byte written while the transmitter is enabled, the shifter is idle and the holding register is empty goes straight to the shifter as a one-cycle `shf_load` pulse. Any other byte waits in the holding register until the shifter acknowledges it with `shf_take`. The receiver side of the channel presents characters with `rx_stb`. The asynchronous reset is released through a two-stage synchronizer.

Top module: `chan_pace`

## Requirements
- R1: During reset and after it, `rdy_n` is 1, `tx_empty` is 1, `rx_avail` is 0, `rx_ovr` is 0 and `shf_load` is 0, and the control byte is zero.
- R2: The control byte has three fields: bit 7 enables the request, bit 6 selects the ready function (1) or the wait function (0), and bit 5 selects receive status (1) or transmit status (0). A control write with bits 7 and 6 set makes `rdy_n` equal to the inverse of the selected status, as that status stands after the same clock edge.
- R3: A control write with bit 6 set and bit 7 clear drives `rdy_n` to 1.
- R4: While the stored control byte has bit 6 clear, `rdy_n` keeps its value through status events and through control writes that also have bit 6 clear.
- R5: A data write while `tx_en` is 1, `shf_idle` is 1 and the holding register is empty (or is being emptied by `shf_take` in the same cycle) produces a one-cycle `shf_load` pulse with the byte on `shf_data`, and `tx_empty` stays 1.
- R6: Any other data write is held rather than dropped: `tx_empty` goes to 0 and `shf_data` shows the held byte. In transmit mode, `rdy_n` goes to 1.
- R7: `shf_take` without a data write in the same cycle sets `tx_empty`. In enabled transmit mode, `rdy_n` then goes to 0.
- R8: Status changes in the unselected direction leave `rdy_n` unchanged.
- R9: `rx_stb` stores `rx_char` in the queue and sets `rx_avail`. `rd_data` shows the oldest stored character, and `data_rd` removes it (first in, first out).
- R10: The queue holds 3 characters. A character that arrives while the queue is full and no read is made replaces the newest entry and sets `rx_ovr`, which stays set until reset. A read of an empty queue has no effect.
- R11: In enabled receive mode, `rdy_n` goes to 0 when a character is stored and goes to 1 when a read empties the queue.
- R12: A character that arrives in the same cycle as a read of a full queue is stored without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| data_wr | input | 1 | Transmit data write strobe |
| data_rd | input | 1 | Receive data read strobe |
| wdata | input | 8 | Host write data |
| tx_en | input | 1 | Transmitter enabled |
| shf_idle | input | 1 | Transmit shifter idle |
| shf_take | input | 1 | Shifter has taken the held byte |
| rx_stb | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rdy_n | output | 1 | Active-low ready request |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_avail | output | 1 | Receive character available |
| rx_ovr | output | 1 | Sticky receive overrun |
| rd_data | output | 8 | Oldest received character |
| shf_load | output | 1 | Pass-through load pulse to shifter |
| shf_data | output | 8 | Byte for the shifter (last written) |

## Verification
Every result of a strobe presented before a rising edge is due right after that same edge. This holds for `rdy_n`, the flags, the load pulse and the shifter byte, which are all registered, and for `rd_data`, which reads the head register. Only the release of reset takes two extra edges, because it passes through the synchronizer. The bench drives inputs on the falling edge, advances its reference model once for that edge, and compares every output on the next falling edge. It skips `rd_data` while the queue is empty.

// File: rtl/chan_pace_pkg.sv
package chan_pace_pkg;
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_FN_BIT  = 6;
  localparam int CTL_SEL_BIT = 5;

  typedef struct packed {
    logic en;     // request function enabled
    logic fn;     // 1: ready function, 0: wait function
    logic rxsel;  // 1: receive status, 0: transmit status
  } ctl_t;
endpackage

// File: rtl/chan_pace_rstsync.sv
module chan_pace_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/chan_pace_txhold.sv
module chan_pace_txhold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          tx_en,
  input  logic          shf_idle,
  input  logic          shf_take,
  output logic          tx_empty,
  output logic          tx_empty_nxt,
  output logic          shf_load,
  output logic [DW-1:0] shf_data
);
  logic          empty_q, empty_d;
  logic          load_q, load_d;
  logic [DW-1:0] data_q;
  logic          empty_eff, pass;

  always_comb begin
    empty_eff = empty_q | shf_take;
    pass      = data_wr & tx_en & shf_idle & empty_eff;
    load_d    = pass;
    if (data_wr) empty_d = pass;
    else         empty_d = empty_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      load_q  <= 1'b0;
    end else begin
      empty_q <= empty_d;
      load_q  <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= wdata;
  end

  assign tx_empty     = empty_q;
  assign tx_empty_nxt = empty_d;
  assign shf_load     = load_q;
  assign shf_data     = data_q;

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !(tx_en && shf_idle && (empty_q || shf_take))) |=> !empty_q);
  // R5
  tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_en && shf_idle && empty_q) |=> (load_q && empty_q));
  // R7
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_take && !data_wr) |=> empty_q);
endmodule

// File: rtl/chan_pace_rxq.sv
module chan_pace_rxq #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_stb,
  input  logic [DW-1:0] rx_char,
  input  logic          data_rd,
  output logic          rx_avail,
  output logic          rx_avail_nxt,
  output logic          rx_ovr,
  output logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] q_q [DEPTH];
  logic [DW-1:0] q_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          ovr_q, ovr_d;
  logic          pop, q_en;

  always_comb begin
    pop  = data_rd && (cnt_q != '0);
    base = pop ? cnt_q - 1'b1 : cnt_q;
    q_en = pop | rx_stb;
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && i < DEPTH - 1) q_d[i] = q_q[i + 1];
      else                      q_d[i] = q_q[i];
    end
    cnt_d = base;
    ovr_d = ovr_q;
    if (rx_stb) begin
      if (base == FULL) begin
        q_d[DEPTH-1] = rx_char;
        ovr_d        = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (base == CW'(i)) q_d[i] = rx_char;
        end
        cnt_d = base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_q[g] <= '0;
      else if (q_en) q_q[g] <= q_d[g];
    end
  end

  assign rx_avail     = (cnt_q != '0);
  assign rx_avail_nxt = (cnt_d != '0);
  assign rx_ovr       = ovr_q;
  assign rd_data      = q_q[0];

  // R10
  rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R10
  rx_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && !data_rd && cnt_q == FULL) |=> (ovr_q && cnt_q == FULL));
  // R12
  rx_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && data_rd && cnt_q == FULL) |=> $stable(ovr_q));
  // R9
  rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> (cnt_q != '0));
endmodule

// File: rtl/chan_pace_rdy.sv
module chan_pace_rdy
  import chan_pace_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  ctl_t ctl_in,
  input  logic tx_empty,
  input  logic tx_empty_nxt,
  input  logic rx_avail,
  input  logic rx_avail_nxt,
  output logic rdy_n
);
  ctl_t ctl_q, ctl_d;
  logic rdy_n_q, rdy_n_d;
  logic sel_nxt_wr, sel_nxt_q;

  always_comb begin
    sel_nxt_wr = ctl_in.rxsel ? rx_avail_nxt : tx_empty_nxt;
    sel_nxt_q  = ctl_q.rxsel  ? rx_avail_nxt : tx_empty_nxt;
    ctl_d      = ctl_wr ? ctl_in : ctl_q;
    rdy_n_d    = rdy_n_q;
    if (ctl_wr) begin
      if (ctl_in.fn) rdy_n_d = ctl_in.en ? !sel_nxt_wr : 1'b1;
    end else if (ctl_q.en && ctl_q.fn) begin
      rdy_n_d = !sel_nxt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rdy_n_q <= 1'b1;
    end else begin
      ctl_q   <= ctl_d;
      rdy_n_q <= rdy_n_d;
    end
  end

  assign rdy_n = rdy_n_q;

  // R2
  rdy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && ctl_q.fn) |-> (rdy_n_q == !(ctl_q.rxsel ? rx_avail : tx_empty)));
  // R3
  rdy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.fn && !ctl_q.en) |-> rdy_n_q);
  // R4
  rdy_wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.fn && !(ctl_wr && ctl_in.fn)) |=> $stable(rdy_n_q));
endmodule

// File: rtl/chan_pace.sv
module chan_pace
  import chan_pace_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wdata,
  input  logic          tx_en,
  input  logic          shf_idle,
  input  logic          shf_take,
  input  logic          rx_stb,
  input  logic [DW-1:0] rx_char,
  output logic          rdy_n,
  output logic          tx_empty,
  output logic          rx_avail,
  output logic          rx_ovr,
  output logic [DW-1:0] rd_data,
  output logic          shf_load,
  output logic [DW-1:0] shf_data
);
  logic rst_n_sync;
  logic tx_empty_nxt, rx_avail_nxt;
  ctl_t ctl_in;

  assign ctl_in = '{en: wdata[CTL_EN_BIT], fn: wdata[CTL_FN_BIT], rxsel: wdata[CTL_SEL_BIT]};

  chan_pace_rstsync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  chan_pace_txhold #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n_sync), .data_wr(data_wr), .wdata(wdata),
    .tx_en(tx_en), .shf_idle(shf_idle), .shf_take(shf_take),
    .tx_empty(tx_empty), .tx_empty_nxt(tx_empty_nxt),
    .shf_load(shf_load), .shf_data(shf_data)
  );

  chan_pace_rxq #(.DW(DW), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n_sync), .rx_stb(rx_stb), .rx_char(rx_char),
    .data_rd(data_rd), .rx_avail(rx_avail), .rx_avail_nxt(rx_avail_nxt),
    .rx_ovr(rx_ovr), .rd_data(rd_data)
  );

  chan_pace_rdy u_rdy (
    .clk(clk), .rst_n(rst_n_sync), .ctl_wr(ctl_wr), .ctl_in(ctl_in),
    .tx_empty(tx_empty), .tx_empty_nxt(tx_empty_nxt),
    .rx_avail(rx_avail), .rx_avail_nxt(rx_avail_nxt), .rdy_n(rdy_n)
  );
endmodule

// File: tb/chan_pace_bench.sv
module chan_pace_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr, data_wr, data_rd, tx_en, shf_idle, shf_take, rx_stb;
  logic [7:0] wdata, rx_char;
  logic       rdy_n, tx_empty, rx_avail, rx_ovr, shf_load;
  logic [7:0] rd_data, shf_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_ctl;
  logic       m_rdy_n, m_txe, m_load, m_ovr;
  logic [7:0] m_sdata;
  logic [7:0] m_q [3];
  int         m_cnt;

  always #2 clk = ~clk;

  chan_pace u_chan_pace (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr),
    .data_rd(data_rd), .wdata(wdata), .tx_en(tx_en), .shf_idle(shf_idle),
    .shf_take(shf_take), .rx_stb(rx_stb), .rx_char(rx_char),
    .rdy_n(rdy_n), .tx_empty(tx_empty), .rx_avail(rx_avail), .rx_ovr(rx_ovr),
    .rd_data(rd_data), .shf_load(shf_load), .shf_data(shf_data)
  );

  task automatic chk1(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk1(tag, "rdy_n", {7'd0, rdy_n}, {7'd0, m_rdy_n});
    chk1(tag, "tx_empty", {7'd0, tx_empty}, {7'd0, m_txe});
    chk1(tag, "rx_avail", {7'd0, rx_avail}, {7'd0, m_cnt != 0});
    chk1(tag, "rx_ovr", {7'd0, rx_ovr}, {7'd0, m_ovr});
    chk1(tag, "shf_load", {7'd0, shf_load}, {7'd0, m_load});
    chk1(tag, "shf_data", shf_data, m_sdata);
    if (m_cnt != 0) chk1(tag, "rd_data", rd_data, m_q[0]);
  endtask

  function automatic void model_reset();
    m_ctl = 8'h00; m_rdy_n = 1'b1; m_txe = 1'b1; m_load = 1'b0;
    m_ovr = 1'b0; m_sdata = 8'h00; m_cnt = 0;
    for (int i = 0; i < 3; i++) m_q[i] = 8'h00;
  endfunction

  function automatic void model_step();
    logic eff, pass, txe_n, sel;
    int   base;
    eff   = m_txe | shf_take;
    pass  = data_wr & tx_en & shf_idle & eff;
    txe_n = data_wr ? pass : eff;
    m_load = pass;
    if (data_wr) m_sdata = wdata;
    base = m_cnt;
    if (data_rd && m_cnt != 0) begin
      m_q[0] = m_q[1]; m_q[1] = m_q[2];
      base = m_cnt - 1;
    end
    if (rx_stb) begin
      if (base == 3) begin m_q[2] = rx_char; m_ovr = 1'b1; end
      else begin m_q[base] = rx_char; base++; end
    end
    m_cnt = base;
    m_txe = txe_n;
    if (ctl_wr) begin
      m_ctl = wdata;
      if (wdata[6]) begin
        sel = wdata[5] ? (m_cnt != 0) : m_txe;
        m_rdy_n = wdata[7] ? !sel : 1'b1;
      end
    end else if (m_ctl[7] && m_ctl[6]) begin
      sel = m_ctl[5] ? (m_cnt != 0) : m_txe;
      m_rdy_n = !sel;
    end
  endfunction

  task automatic idle_inputs();
    ctl_wr = 0; data_wr = 0; data_rd = 0; shf_take = 0; rx_stb = 0;
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic wr_ctl(logic [7:0] v, string tag);
    ctl_wr = 1; wdata = v; tick(tag);
  endtask

  task automatic wr_data(logic [7:0] v, string tag);
    data_wr = 1; wdata = v; tick(tag);
  endtask

  task automatic push(logic [7:0] v, string tag);
    rx_stb = 1; rx_char = v; tick(tag);
  endtask

  task automatic pop(string tag);
    data_rd = 1; tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle_inputs();
    wdata = 0; rx_char = 0; tx_en = 1; shf_idle = 1;
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");

    // transmit mode, enabled ready function
    wr_ctl(8'hC0, "R2");                         // empty -> ready
    shf_idle = 0; wr_data(8'hA5, "R6");           // held, not ready
    push(8'h11, "R8");                            // rx event, tx mode: no change
    shf_take = 1; tick("R7");                     // held byte taken -> ready
    shf_idle = 1; wr_data(8'h3C, "R5");           // pass-through
    tx_en = 0; wr_data(8'h77, "R6");              // disabled -> held
    tx_en = 1;
    wr_ctl(8'h40, "R3");                          // ready fn, disabled -> 1
    wr_ctl(8'h80, "R4");                          // wait function
    shf_take = 1; tick("R4");                     // status change, frozen
    wr_ctl(8'h00, "R4");
    pop("R9");                                    // drain 0x11
    pop("R10");                                   // read of empty: no effect

    // receive mode
    wr_ctl(8'hE0, "R2");
    push(8'h21, "R11");
    push(8'h22, "R9");
    push(8'h23, "R9");
    push(8'h24, "R10");                           // overrun replaces newest
    rx_stb = 1; rx_char = 8'h25; data_rd = 1; tick("R12");
    shf_idle = 0; wr_data(8'h99, "R8");           // tx event, rx mode: no change
    shf_idle = 1;
    pop("R9"); pop("R9"); pop("R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      ctl_wr   = (r[3:0] == 4'd0);
      wdata    = ctl_wr ? {8'($urandom)} : 8'($urandom);
      data_wr  = !ctl_wr && r[4] && r[5];
      data_rd  = r[6];
      rx_stb   = r[7] ^ r[0];
      rx_char  = 8'($urandom);
      shf_take = ($urandom % 4) == 0;
      tx_en    = ($urandom % 5) != 0;
      shf_idle = ($urandom % 2) == 0;
      tick(ctl_wr ? "R2" : (m_ctl[5] ? "R11" : "R6"));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule